// File: doc/BRIEF.md
# Event-Driven Output Set/Clear Resolver

This block keeps the state of a bank of timer output lines and updates them from a vector of single-cycle event pulses. Each output has two event masks. One mask names the events that drive the output high. The other names the events that drive it low. A per-output reversal bit swaps the meaning of the two masks.

When one clock cycle asks an output to be both driven high and driven low, a 2-bit policy per output decides the result. The policy can keep the present value, force a level, or invert the output. Inverting is the usual way to make one event toggle a line: the event is placed in both masks and the policy is set to invert.

Configuration is loaded through a plain write port: a strobe, a word address and a data word. The event vector comes from a counter and match stage outside this block. The outputs feed pin logic, also outside this block.

Top module: `evt_out_resolver`

## Requirements
- R1: After a synchronous active-high reset, the following are all 0: every output, every mask, every policy field and every reversal bit.
- R2: The write port uses these word addresses. Address 0 holds the policy word, with output k's 2-bit policy in bits 2k+1:2k. Address 1 holds the reversal word, with bit k belonging to output k. Address 2+k holds the high-driving event mask of output k, and address 2+NUM_OUTS+k holds its low-driving mask; event j is bit j in both. A write to any higher address changes nothing.
- R3: If an output's enabled events request only the high-driving action and its reversal bit is 0, the output is 1 after the clock edge at which the events are sampled. A request for only the low-driving action gives 0.
- R4: If no event present on an output's masks is active, the output holds its value. Active events that appear in neither mask have no effect.
- R5: With the reversal bit at 1, a lone high-driving request gives 0 and a lone low-driving request gives 1.
- R6: Policy code 0 keeps the output unchanged when both requests occur in the same cycle.
- R7: Policy code 1 gives 1 on a conflict, or 0 when the reversal bit is 1.
- R8: Policy code 2 gives 0 on a conflict, or 1 when the reversal bit is 1.
- R9: Policy code 3 inverts the output on a conflict, whatever the reversal bit.
- R10: A conflict arises both when one event is in both masks and when two different events supply the two requests.
- R11: A write takes effect from the next cycle. Events sampled in the same cycle as a write use the old configuration, and a write with no active event leaves every output unchanged.
- R12: Each output depends only on its own masks, policy and reversal bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | ADDR_W | Configuration word address |
| cfg_wdata | input | DATA_W | Configuration write data |
| evt_i | input | NUM_EVENTS | Event pulses sampled each cycle |
| out_o | output | NUM_OUTS | Registered output levels |

## Verification
The bench targets the four policy codes, each tried with the reversal bit clear and with it set. A design that ignored the reversal bit on a conflict would force the wrong level, and one that treated code 3 as a fixed level would stop toggling after the first event. It checks a single event placed in both masks and two separate events that collide; a design that only compared different events would let the self-conflict fall through as a plain set. It also writes a register in the same cycle as an event, which catches a design that uses the new configuration one cycle too early. Events that appear in no mask and writes to unused addresses must leave the outputs unchanged.

// File: rtl/evt_out_pkg.sv
package evt_out_pkg;

    typedef enum logic [1:0] {
        RES_HOLD = 2'd0,
        RES_HIGH = 2'd1,
        RES_LOW  = 2'd2,
        RES_FLIP = 2'd3
    } res_code_e;

    typedef struct packed {
        logic hi_req;
        logic lo_req;
    } out_req_t;

    localparam int ADDR_POLICY   = 0;
    localparam int ADDR_REVERSE  = 1;
    localparam int ADDR_MASK_BASE = 2;

    // Next output value from the present value, the requests, reversal and policy.
    function automatic logic next_level(
        input logic      cur,
        input out_req_t  req,
        input logic      rev,
        input res_code_e code
    );
        logic nxt;
        nxt = cur;
        if (req.hi_req && req.lo_req) begin
            unique case (code)
                RES_HOLD: nxt = cur;
                RES_HIGH: nxt = ~rev;
                RES_LOW:  nxt = rev;
                RES_FLIP: nxt = ~cur;
                default:  nxt = cur;
            endcase
        end else if (req.hi_req) begin
            nxt = ~rev;
        end else if (req.lo_req) begin
            nxt = rev;
        end
        return nxt;
    endfunction

endpackage

// File: rtl/evt_out_cfg_regs.sv
module evt_out_cfg_regs
    import evt_out_pkg::*;
#(
    parameter int NUM_EVENTS = 8,
    parameter int NUM_OUTS   = 5,
    parameter int ADDR_W     = 4,
    parameter int DATA_W     = 16
) (
    input  logic                                 clk,
    input  logic                                 rst,
    input  logic                                 cfg_we,
    input  logic [ADDR_W-1:0]                    cfg_addr,
    input  logic [DATA_W-1:0]                    cfg_wdata,
    output logic [NUM_OUTS-1:0][NUM_EVENTS-1:0]  hi_mask,
    output logic [NUM_OUTS-1:0][NUM_EVENTS-1:0]  lo_mask,
    output logic [2*NUM_OUTS-1:0]                policy,
    output logic [NUM_OUTS-1:0]                  reverse
);
    localparam int LO_BASE = ADDR_MASK_BASE + NUM_OUTS;

    logic unused_ok;
    assign unused_ok = &{1'b0, cfg_wdata};

    always_ff @(posedge clk) begin
        if (rst) begin
            policy  <= '0;
            reverse <= '0;
        end else if (cfg_we) begin
            if (cfg_addr == ADDR_W'(ADDR_POLICY))
                policy <= cfg_wdata[2*NUM_OUTS-1:0];
            if (cfg_addr == ADDR_W'(ADDR_REVERSE))
                reverse <= cfg_wdata[NUM_OUTS-1:0];
        end
    end

    for (genvar k = 0; k < NUM_OUTS; k++) begin : g_mask
        always_ff @(posedge clk) begin
            if (rst) begin
                hi_mask[k] <= '0;
                lo_mask[k] <= '0;
            end else if (cfg_we) begin
                if (cfg_addr == ADDR_W'(ADDR_MASK_BASE + k))
                    hi_mask[k] <= cfg_wdata[NUM_EVENTS-1:0];
                if (cfg_addr == ADDR_W'(LO_BASE + k))
                    lo_mask[k] <= cfg_wdata[NUM_EVENTS-1:0];
            end
        end
    end

    // R2
    policy_write_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_addr == ADDR_W'(ADDR_POLICY)) |=>
            (policy == $past(cfg_wdata[2*NUM_OUTS-1:0])));

    // R1
    cfg_reset_chk: assert property (@(posedge clk)
        $past(rst) |-> (policy == '0 && reverse == '0));

endmodule

// File: rtl/evt_out_req_decode.sv
module evt_out_req_decode
    import evt_out_pkg::*;
#(
    parameter int NUM_EVENTS = 8,
    parameter int NUM_OUTS   = 5
) (
    input  logic [NUM_EVENTS-1:0]                evt,
    input  logic [NUM_OUTS-1:0][NUM_EVENTS-1:0]  hi_mask,
    input  logic [NUM_OUTS-1:0][NUM_EVENTS-1:0]  lo_mask,
    output out_req_t [NUM_OUTS-1:0]              req
);
    for (genvar k = 0; k < NUM_OUTS; k++) begin : g_req
        always_comb begin
            req[k].hi_req = |(evt & hi_mask[k]);
            req[k].lo_req = |(evt & lo_mask[k]);
        end
    end
endmodule

// File: rtl/evt_out_cell.sv
module evt_out_cell
    import evt_out_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  out_req_t  req,
    input  logic      rev,
    input  res_code_e code,
    output logic      level
);
    always_ff @(posedge clk) begin
        if (rst) level <= 1'b0;
        else     level <= next_level(level, req, rev, code);
    end

    // R4
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!req.hi_req && !req.lo_req) |=> $stable(level));

    // R6
    conflict_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (req.hi_req && req.lo_req && code == RES_HOLD) |=> $stable(level));

    // R9
    conflict_flip_chk: assert property (@(posedge clk) disable iff (rst)
        (req.hi_req && req.lo_req && code == RES_FLIP) |=> (level != $past(level)));

    // R3
    lone_high_chk: assert property (@(posedge clk) disable iff (rst)
        (req.hi_req && !req.lo_req && !rev) |=> level);

    // R5
    lone_high_rev_chk: assert property (@(posedge clk) disable iff (rst)
        (req.hi_req && !req.lo_req && rev) |=> !level);

    // R1
    cell_reset_chk: assert property (@(posedge clk) $past(rst) |-> !level);
endmodule

// File: rtl/evt_out_resolver.sv
module evt_out_resolver
    import evt_out_pkg::*;
#(
    parameter int NUM_EVENTS = 8,
    parameter int NUM_OUTS   = 5,
    parameter int DATA_W     = 16,
    parameter int ADDR_W     = $clog2(ADDR_MASK_BASE + 2*NUM_OUTS)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cfg_we,
    input  logic [ADDR_W-1:0]     cfg_addr,
    input  logic [DATA_W-1:0]     cfg_wdata,
    input  logic [NUM_EVENTS-1:0] evt_i,
    output logic [NUM_OUTS-1:0]   out_o
);
    logic [NUM_OUTS-1:0][NUM_EVENTS-1:0] hi_mask;
    logic [NUM_OUTS-1:0][NUM_EVENTS-1:0] lo_mask;
    logic [2*NUM_OUTS-1:0]               policy;
    logic [NUM_OUTS-1:0]                 reverse;
    out_req_t [NUM_OUTS-1:0]             req;

    evt_out_cfg_regs #(
        .NUM_EVENTS(NUM_EVENTS), .NUM_OUTS(NUM_OUTS),
        .ADDR_W(ADDR_W), .DATA_W(DATA_W)
    ) u_cfg (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .hi_mask(hi_mask), .lo_mask(lo_mask),
        .policy(policy), .reverse(reverse)
    );

    evt_out_req_decode #(
        .NUM_EVENTS(NUM_EVENTS), .NUM_OUTS(NUM_OUTS)
    ) u_dec (
        .evt(evt_i), .hi_mask(hi_mask), .lo_mask(lo_mask), .req(req)
    );

    for (genvar k = 0; k < NUM_OUTS; k++) begin : g_cell
        evt_out_cell u_cell (
            .clk(clk), .rst(rst), .req(req[k]), .rev(reverse[k]),
            .code(res_code_e'(policy[2*k +: 2])), .level(out_o[k])
        );
    end

    // R11
    quiet_write_chk: assert property (@(posedge clk) disable iff (rst)
        (evt_i == '0) |=> $stable(out_o));
endmodule

// File: tb/evt_out_resolver_bench.sv
module evt_out_resolver_bench;
    localparam int NE = 8;
    localparam int NO = 5;
    localparam int DW = 16;
    localparam int AW = 4;
    localparam int LO = 2 + NO;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_we = 1'b0;
    logic [AW-1:0] cfg_addr = '0;
    logic [DW-1:0] cfg_wdata = '0;
    logic [NE-1:0] evt_i = '0;
    logic [NO-1:0] out_o;

    always #5 clk = ~clk;

    evt_out_resolver #(.NUM_EVENTS(NE), .NUM_OUTS(NO), .DATA_W(DW), .ADDR_W(AW)) u_evt_out_resolver (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .evt_i(evt_i), .out_o(out_o)
    );

    logic [NE-1:0]   m_hi [NO];
    logic [NE-1:0]   m_lo [NO];
    logic [2*NO-1:0] m_pol;
    logic [NO-1:0]   m_rev;
    logic [NO-1:0]   m_out;
    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    function automatic logic [NO-1:0] model_next(input logic [NO-1:0] cur, input logic [NE-1:0] ev);
        logic [NO-1:0] n;
        n = cur;
        for (int k = 0; k < NO; k++) begin
            logic h, l;
            h = |(ev & m_hi[k]);
            l = |(ev & m_lo[k]);
            if (h && l) begin
                case (m_pol[2*k +: 2])
                    2'd1: n[k] = ~m_rev[k];
                    2'd2: n[k] = m_rev[k];
                    2'd3: n[k] = ~cur[k];
                    default: n[k] = cur[k];
                endcase
            end else if (h) n[k] = ~m_rev[k];
            else if (l)     n[k] = m_rev[k];
        end
        return n;
    endfunction

    task automatic model_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        if (a == 0) m_pol = d[2*NO-1:0];
        else if (a == 1) m_rev = d[NO-1:0];
        else if (a >= 2 && a < 2 + NO) m_hi[a-2] = d[NE-1:0];
        else if (a >= LO && a < LO + NO) m_lo[a-LO] = d[NE-1:0];
    endtask

    task automatic check(input string tag, input logic [NO-1:0] exp);
        checks++;
        if (out_o !== exp) begin
            fails++;
            $display("FAIL %s: out_o=%b expected=%b", tag, out_o, exp);
        end
    endtask

    // One cycle: drive at the falling edge, compare after the next rising edge.
    task automatic step(input logic [NE-1:0] ev, input logic we, input logic [AW-1:0] a,
                        input logic [DW-1:0] d, input string tag);
        evt_i = ev; cfg_we = we; cfg_addr = a; cfg_wdata = d;
        m_out = model_next(m_out, ev);
        if (we) model_write(a, d);
        @(negedge clk);
        check(tag, m_out);
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input string tag);
        step('0, 1'b1, a, d, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: out_o=%b expected=finish", out_o);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1234abcd));
        for (int k = 0; k < NO; k++) begin m_hi[k] = '0; m_lo[k] = '0; end
        m_pol = '0; m_rev = '0; m_out = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1 reset outputs", '0);
        step(8'hFF, 0, 0, 0, "R1 masks cleared by reset");

        wr(2, 16'h0001, "R2 high mask out0");
        wr(LO, 16'h0002, "R2 low mask out0");
        step(8'h01, 0, 0, 0, "R3 lone high");
        step(8'h02, 0, 0, 0, "R3 lone low");
        step(8'h01, 0, 0, 0, "R3 lone high again");
        step(8'h00, 0, 0, 0, "R4 idle hold");
        step(8'h80, 0, 0, 0, "R4 unmapped event");
        wr(4'd15, 16'hFFFF, "R2 unused address");
        step(8'hFF, 0, 0, 0, "R2 unused write no effect");
        step(8'h03, 0, 0, 0, "R6 conflict hold code0");
        wr(0, 16'h0001, "R2 policy write");
        step(8'h02, 0, 0, 0, "R3 clear before R7");
        step(8'h03, 0, 0, 0, "R7 conflict code1");
        wr(0, 16'h0002, "R2 policy code2");
        step(8'h03, 0, 0, 0, "R8 conflict code2");
        wr(2 + 1, 16'h0010, "R2 high mask out1");
        wr(LO + 1, 16'h0010, "R2 low mask out1");
        wr(0, 16'h000E, "R2 policy out1 flip");
        step(8'h10, 0, 0, 0, "R9 R10 self conflict toggle");
        step(8'h10, 0, 0, 0, "R9 R10 toggle back");
        step(8'h13, 0, 0, 0, "R12 two outputs at once");
        wr(1, 16'h0003, "R2 reversal write");
        step(8'h01, 0, 0, 0, "R5 reversed lone high");
        step(8'h02, 0, 0, 0, "R5 reversed lone low");
        wr(0, 16'h000D, "R2 policy code1 flip");
        step(8'h03, 0, 0, 0, "R7 reversed conflict code1");
        wr(0, 16'h000E, "R2 policy code2 flip");
        step(8'h03, 0, 0, 0, "R8 reversed conflict code2");
        step(8'h10, 0, 0, 0, "R9 toggle with reversal");
        step(8'h03, 1, 0, 16'h000C, "R11 event uses old policy");
        step(8'h03, 0, 0, 0, "R11 new policy next cycle");
        wr(2, 16'h0000, "R11 quiet write");

        for (int i = 0; i < 3000; i++) begin
            logic we;
            logic [AW-1:0] a;
            we = ($urandom % 4) == 0;
            a  = AW'($urandom % 14);
            step(NE'($urandom), we, a, DW'($urandom), "R12 random");
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule